// File: doc/BRIEF.md
# Rail Voltage Threshold Monitor

This block supervises a single supply rail. In analog mode it watches a stream of converter samples, each tagged with a channel number. It keeps only the samples whose channel matches the rail's selected channel. From those it derives a power-good level with hysteresis, and it checks every sample against four run-time thresholds: undervoltage warning, undervoltage fault, overvoltage warning and overvoltage fault. A flag is declared only after its condition has held for a programmable number of consecutive samples of this rail. While the rail is not yet good, every flag is suppressed, so a normal ramp-up is never reported.

In external mode the thresholds play no part. An off-chip power-good input is filtered by a stability debouncer with an exponential interval, and the filtered level becomes the rail's power-good output. If that level drops, an undervoltage fault is raised.

Flags stay latched until a clear command arrives. Any latched flag drives an active-low alert. A separate bit records whether this rail raised its alert while no other rail was already alerting.

Top module: `rail_vmon`

## Requirements
- R1: After reset, `pg` is 0, `first_alert` is 0, `alert_n` is 1 and `stat` is 0.
- R2: A sample affects the block only when `smp_valid` is 1 and `smp_chan` equals `cfg_chan`. Samples on any other channel are ignored.
- R3: In analog mode, `pg` rises on a matching sample with `smp_data >= thr_on` and falls on a matching sample with `smp_data < thr_off`. Between those two levels it holds its value.
- R4: There are four strict comparisons, each latched in its own bit of `stat`:
  - bit 0 is undervoltage warning (`smp_data < thr_uv_warn`);
  - bit 1 is undervoltage fault (`smp_data < thr_uv_flt`);
  - bit 2 is overvoltage warning (`smp_data > thr_ov_warn`);
  - bit 3 is overvoltage fault (`smp_data > thr_ov_flt`).
- R5: A `stat` bit is set on the `cfg_samples`-th consecutive matching sample that meets its condition. A matching sample that fails the condition restarts that bit's count. A `cfg_samples` value of 0 acts as 1.
- R6: While `pg` is 0 in analog mode, no `stat` bit is set, and a sample taken while `pg` is 0 restarts every count.
- R7: `stat` bits stay set until `clear_faults` is 1 at a clock edge. That edge zeroes `stat` and `first_alert`, and the clear wins over any set arriving in the same cycle.
- R8: `alert_n` is 0 exactly when some `stat` bit is set. `first_alert` sets when a flag is latched while `stat` is all zero and `other_alert` is 0.
- R9: When `cfg_ext_pg` is 1, samples are ignored and `pg` equals the debounced external input.
- R10: The debounced level takes the value of `ext_pg_in` once that input has held the same value for 2^n consecutive clock cycles, where n is `cfg_db_level`. Levels above 27 act as 27.
- R11: In external mode, a fall of the debounced level sets `stat` bit 1 (undervoltage fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chan | input | CHW | Channel assigned to this rail |
| cfg_ext_pg | input | 1 | 1 selects external power-good mode |
| cfg_samples | input | CNTW | Consecutive samples needed to declare a flag |
| cfg_db_level | input | LVW | Debounce level n, interval 2^n cycles |
| thr_on | input | DW | Power-good assert level |
| thr_off | input | DW | Power-good deassert level |
| thr_uv_warn | input | DW | Undervoltage warning threshold |
| thr_uv_flt | input | DW | Undervoltage fault threshold |
| thr_ov_warn | input | DW | Overvoltage warning threshold |
| thr_ov_flt | input | DW | Overvoltage fault threshold |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CHW | Channel tag of the sample |
| smp_data | input | DW | Unsigned sample value |
| ext_pg_in | input | 1 | External power-good input |
| other_alert | input | 1 | 1 when another rail already alerts |
| clear_faults | input | 1 | Clears latched flags |
| pg | output | 1 | Rail power-good status |
| stat | output | 4 | Latched flags {ov_flt, ov_warn, uv_flt, uv_warn} |
| first_alert | output | 1 | This rail alerted first |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench builds the block with its default parameters:
- 12-bit samples and thresholds;
- 4-bit channel tags;
- an 8-bit sample counter;
- a 28-bit debounce run counter.

Because the debounce level and the sample count are run-time inputs, levels 3 and 0 and sample counts of 3 and 0 put the 8-cycle and single-cycle debounce windows and the counting edges within a few cycles. Lowering the power-good deassert level at run time makes the undervoltage fault reachable while `pg` is still high.

// File: rtl/rail_vmon.sv
module rail_vmon #(
  parameter int DW   = 12,
  parameter int CHW  = 4,
  parameter int CNTW = 8,
  parameter int LVW  = 5,
  parameter int RUNW = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CHW-1:0]  cfg_chan,
  input  logic            cfg_ext_pg,
  input  logic [CNTW-1:0] cfg_samples,
  input  logic [LVW-1:0]  cfg_db_level,
  input  logic [DW-1:0]   thr_on,
  input  logic [DW-1:0]   thr_off,
  input  logic [DW-1:0]   thr_uv_warn,
  input  logic [DW-1:0]   thr_uv_flt,
  input  logic [DW-1:0]   thr_ov_warn,
  input  logic [DW-1:0]   thr_ov_flt,
  input  logic            smp_valid,
  input  logic [CHW-1:0]  smp_chan,
  input  logic [DW-1:0]   smp_data,
  input  logic            ext_pg_in,
  input  logic            other_alert,
  input  logic            clear_faults,
  output logic            pg,
  output logic [3:0]      stat,
  output logic            first_alert,
  output logic            alert_n
);
  localparam int NCMP = 4;
  localparam logic [CNTW-1:0] CNT_MAX = '1;
  localparam logic [RUNW-1:0] RUN_MAX = '1;
  localparam logic [LVW-1:0]  LVL_TOP = LVW'(RUNW - 1);

  logic            apg, db, in_q, first_q;
  logic [RUNW-1:0] run;
  logic [3:0]      stat_q;
  logic [NCMP-1:0] cond, set_an;

  wire hit = smp_valid && (smp_chan == cfg_chan) && !cfg_ext_pg;

  assign cond = {smp_data > thr_ov_flt, smp_data > thr_ov_warn,
                 smp_data < thr_uv_flt, smp_data < thr_uv_warn};

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic [CNTW-1:0] cnt;
    wire qual = cond[i] && apg;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt <= '0;
      else if (hit) cnt <= qual ? ((cnt == CNT_MAX) ? cnt : cnt + CNTW'(1)) : '0;
    assign set_an[i] = hit && qual &&
                       ((CNTW+1)'(cnt) + (CNTW+1)'(1) >= (CNTW+1)'(cfg_samples));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) apg <= 1'b0;
    else if (hit) begin
      if (!apg && smp_data >= thr_on) apg <= 1'b1;
      else if (apg && smp_data < thr_off) apg <= 1'b0;
    end

  wire [LVW-1:0]  lvl_c  = (cfg_db_level > LVL_TOP) ? LVL_TOP : cfg_db_level;
  wire [RUNW-1:0] run_nx = (ext_pg_in == in_q) ? ((run == RUN_MAX) ? run : run + RUNW'(1))
                                               : RUNW'(1);
  wire            db_nx  = (run_nx >= (RUNW'(1) << lvl_c)) ? ext_pg_in : db;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_q <= 1'b0;
      run  <= '0;
      db   <= 1'b0;
    end else begin
      in_q <= ext_pg_in;
      run  <= run_nx;
      db   <= db_nx;
    end

  wire       loss    = cfg_ext_pg && db && !db_nx;
  wire [3:0] set_all = set_an | {2'b00, loss, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_q  <= '0;
      first_q <= 1'b0;
    end else if (clear_faults) begin
      stat_q  <= '0;
      first_q <= 1'b0;
    end else begin
      stat_q <= stat_q | set_all;
      if (stat_q == '0 && set_all != '0 && !other_alert) first_q <= 1'b1;
    end

  assign pg          = cfg_ext_pg ? db : apg;
  assign stat        = stat_q;
  assign first_alert = first_q;
  assign alert_n     = ~|stat_q;

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_faults |=> stat == 4'b0000 && !first_alert);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_faults |=> (stat & $past(stat)) == $past(stat));

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_faults && !cfg_ext_pg && !pg) |=> stat == $past(stat));

  p_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    first_alert |-> !alert_n);

  p_pg_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(apg) |-> $past(hit) && $past(smp_data) >= $past(thr_on));

  p_db_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    db != $past(db) |-> db == $past(ext_pg_in));
endmodule

// File: tb/tb_rail_vmon.sv
`timescale 1ns/100ps
module tb_rail_vmon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_chan = 4'd5;
  logic        cfg_ext_pg = 1'b0;
  logic [7:0]  cfg_samples = 8'd3;
  logic [4:0]  cfg_db_level = 5'd3;
  logic [11:0] thr_on = 12'd2000, thr_off = 12'd1800;
  logic [11:0] thr_uv_warn = 12'd1900, thr_uv_flt = 12'd1700;
  logic [11:0] thr_ov_warn = 12'd2200, thr_ov_flt = 12'd2400;
  logic        smp_valid = 1'b0;
  logic [3:0]  smp_chan = '0;
  logic [11:0] smp_data = '0;
  logic        ext_pg_in = 1'b0, other_alert = 1'b0, clear_faults = 1'b0;
  logic        pg, first_alert, alert_n;
  logic [3:0]  stat;

  always #2.5 clk = ~clk;

  rail_vmon dut (
    .clk(clk), .rst_n(rst_n), .cfg_chan(cfg_chan), .cfg_ext_pg(cfg_ext_pg),
    .cfg_samples(cfg_samples), .cfg_db_level(cfg_db_level),
    .thr_on(thr_on), .thr_off(thr_off), .thr_uv_warn(thr_uv_warn),
    .thr_uv_flt(thr_uv_flt), .thr_ov_warn(thr_ov_warn), .thr_ov_flt(thr_ov_flt),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .ext_pg_in(ext_pg_in), .other_alert(other_alert), .clear_faults(clear_faults),
    .pg(pg), .stat(stat), .first_alert(first_alert), .alert_n(alert_n));

  typedef struct { string req; logic [6:0] exp; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  wire [6:0] obs = {pg, first_alert, alert_n, stat};

  task automatic expect_obs(input string req, input logic [6:0] e);
    item_t it;
    it.req = req;
    it.exp = e;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] ch, input logic [11:0] d);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clr();
    clear_faults = 1'b1;
    @(negedge clk);
    clear_faults = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (obs !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", it.req, obs, it.exp);
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_obs("R1 reset", 7'b0010000);
    repeat (3) send(4'd5, 12'd100);
    expect_obs("R6 masked ramp", 7'b0010000);
    send(4'd5, 12'd2000);
    expect_obs("R3 pg on", 7'b1010000);
    repeat (3) send(4'd4, 12'd3000);
    expect_obs("R2 other channel", 7'b1010000);
    send(4'd5, 12'd1850); send(4'd5, 12'd1850); send(4'd5, 12'd2000);
    send(4'd5, 12'd1850); send(4'd5, 12'd1850);
    expect_obs("R5 count restart", 7'b1010000);
    send(4'd5, 12'd1850);
    expect_obs("R4 R8 uv warn first", 7'b1100001);
    tick(3);
    expect_obs("R7 latched", 7'b1100001);
    clr();
    expect_obs("R7 clear", 7'b1010000);
    other_alert = 1'b1;
    repeat (3) send(4'd5, 12'd2300);
    expect_obs("R8 not first", 7'b1000100);
    other_alert = 1'b0;
    clr();
    send(4'd5, 12'd2000);
    send(4'd5, 12'd2500); send(4'd5, 12'd2500);
    expect_obs("R5 two of three", 7'b1010000);
    send(4'd5, 12'd2500);
    expect_obs("R4 ov fault", 7'b1101100);
    clr();
    send(4'd5, 12'd2000);
    send(4'd5, 12'd1850);
    expect_obs("R3 hold above off", 7'b1010000);
    send(4'd5, 12'd1750);
    expect_obs("R3 pg off", 7'b0010000);
    send(4'd5, 12'd1990);
    expect_obs("R3 R6 hysteresis", 7'b0010000);
    send(4'd5, 12'd2000);
    expect_obs("R3 pg back", 7'b1010000);
    thr_off = 12'd1500;
    repeat (3) send(4'd5, 12'd1650);
    expect_obs("R4 uv fault", 7'b1100011);
    clr();
    clear_faults = 1'b1;
    send(4'd5, 12'd1650);
    clear_faults = 1'b0;
    expect_obs("R7 clear wins", 7'b1010000);
    thr_off = 12'd1800;
    send(4'd5, 12'd2000);
    cfg_ext_pg = 1'b1;
    expect_obs("R9 ext select", 7'b0010000);
    repeat (3) send(4'd5, 12'd2500);
    expect_obs("R9 samples ignored", 7'b0010000);
    ext_pg_in = 1'b1;
    tick(7);
    expect_obs("R10 before interval", 7'b0010000);
    tick(1);
    expect_obs("R10 after interval", 7'b1010000);
    ext_pg_in = 1'b0;
    tick(4);
    ext_pg_in = 1'b1;
    tick(10);
    expect_obs("R10 glitch rejected", 7'b1010000);
    ext_pg_in = 1'b0;
    tick(7);
    expect_obs("R10 loss pending", 7'b1010000);
    tick(1);
    expect_obs("R11 loss fault", 7'b0100010);
    clr();
    cfg_db_level = 5'd0;
    ext_pg_in = 1'b1;
    tick(1);
    expect_obs("R10 level zero", 7'b1010000);
    cfg_ext_pg = 1'b0;
    cfg_samples = 8'd0;
    send(4'd5, 12'd2300);
    expect_obs("R5 zero count", 7'b1100100);
    tick(2);
    finish_run();
  end
endmodule